// File: doc/BRIEF.md
# Zone-Protected Address Translation Buffer

This block is a small, fully associative translation buffer for an embedded core whose entries are loaded by software. Each entry maps one page of effective addresses to real addresses. Every entry has its own power-of-two page size, a process tag, and three permission bits. Lookup is combinational. The block compares the presented address and current process tag against every valid entry, picks the lowest-numbered match, and splices the entry's real page bits onto the untouched offset bits of the address.

Access rights are not taken from the entry alone. Each entry names one of sixteen zones through a four-bit selector held in its attribute byte. The two-bit code of that zone is read from a 32-bit zone register. The code can grant full rights, defer to the entry's bits, or forbid user access outright, depending on whether the access is privileged. The block reports a hit flag, the real address, the granted rights, a fault class and a syndrome word for the exception logic that sits around it. Entries are written through a synchronous load port.

Top module: `tlbz_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss.
- R2: Only an entry whose valid bit is set can match; loading an entry with valid low removes it from lookup.
- R3: An entry with process tag 0 matches any current tag; a nonzero tag matches only when it equals the current tag.
- R4: An entry of size code s covers 2^s bytes; it matches when the address with its low s bits cleared equals the stored effective page number.
- R5: On a hit the real address is the stored real page number with its low s bits cleared, ORed with the low s bits of the address; on a miss it is 0.
- R6: When several entries match, the one with the lowest index supplies the result.
- R7: The zone of an entry is attribute bits 7:4; its code is zone register bits [31-2z:30-2z] (zone 0 at the top two bits).
- R8: Zone code 3 grants read, write and execute (rights 3'b111) in both modes; zone code 2 grants 3'b111 to privileged accesses and the entry's permission bits to user accesses.
- R9: Zone code 0 on a user access gives fault class 2 (zone fault), rights 0 and syndrome 32'h0040_0000; on a privileged access it acts as code 1.
- R10: Zone code 1 grants the entry's permission bits (bit 0 read, bit 1 write, bit 2 execute); an access type whose bit is clear gives fault class 3 (protection) with syndrome 0.
- R11: A lookup matching no entry gives hit 0, rights 0, syndrome 0 and fault class 1 (miss); a granted access gives fault class 0.
- R12: A load request takes effect at the next rising clock edge; the lookup in the cycle of the request still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ldEn | input | 1 | Load one entry at the next edge |
| ldIdx | input | 3 | Entry index to load |
| ldValid | input | 1 | Valid bit for the loaded entry |
| ldPid | input | 8 | Process tag of the entry (0 = any) |
| ldEpn | input | 32 | Effective page number (low bits zero) |
| ldRpn | input | 32 | Real page number |
| ldSizeLog | input | 5 | Page size as log2 of bytes |
| ldAttr | input | 8 | Attribute byte, zone selector in bits 7:4 |
| ldPerm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| zoneReg | input | 32 | Sixteen two-bit zone codes |
| curPid | input | 8 | Current process tag |
| lkAddr | input | 32 | Effective address to translate |
| lkType | input | 2 | 0 fetch, 1 load, 2 store (3 treated as load) |
| lkUser | input | 1 | 1 for an unprivileged access |
| hit | output | 1 | An entry matched |
| realAddr | output | 32 | Translated address |
| rights | output | 3 | Granted rights, same bit order as ldPerm |
| fault | output | 2 | 0 none, 1 miss, 2 zone fault, 3 protection fault |
| syndrome | output | 32 | Syndrome word for the fault |

## Verification
The hardest case to reach is an address that two entries both cover, where the lower-numbered one is rejected only by its process tag or by a finer page mask, so the result must come from a higher entry. The bench loads a small 4 KB page inside a larger 64 KB page with a wildcard tag. It then steps the current tag and the address offset so that each reason for rejection, and the priority win, is seen in turn. A second hard point is the zone code position, which the bench reaches by repeating one lookup with a zone register where only one zone's field differs.

// File: rtl/tlbz_pkg.sv
package tlbz_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_MISS = 2'd1,
    FLT_ZONE = 2'd2,
    FLT_PROT = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic setValid;
  } strobe_t;

  localparam logic [31:0] ZONE_SYNDROME = 32'h0040_0000;

endpackage

// File: rtl/tlbz_datapath.sv
module tlbz_datapath
  import tlbz_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int PID_W   = 8,
  parameter int SIZE_W  = 5,
  parameter int ATTR_W  = 8,
  parameter int PERM_W  = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic [PID_W-1:0]  ldPid,
  input  logic [ADDR_W-1:0] ldEpn,
  input  logic [ADDR_W-1:0] ldRpn,
  input  logic [SIZE_W-1:0] ldSizeLog,
  input  logic [ATTR_W-1:0] ldAttr,
  input  logic [PERM_W-1:0] ldPerm,
  input  logic [PID_W-1:0]  curPid,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              anyHit,
  output logic [ATTR_W-1:0] hitAttr,
  output logic [PERM_W-1:0] hitPerm,
  output logic [ADDR_W-1:0] realAddr
);

  logic [ENTRIES-1:0] validQ;
  logic [PID_W-1:0]   pidQ  [ENTRIES];
  logic [ADDR_W-1:0]  epnQ  [ENTRIES];
  logic [ADDR_W-1:0]  rpnQ  [ENTRIES];
  logic [SIZE_W-1:0]  sizeQ [ENTRIES];
  logic [ATTR_W-1:0]  attrQ [ENTRIES];
  logic [PERM_W-1:0]  permQ [ENTRIES];
  logic [ADDR_W-1:0]  maskE [ENTRIES];
  logic [ENTRIES-1:0] matchE;
  logic [IDX_W-1:0]   selIdx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic wrHere;
    assign wrHere = strobe.load && (ldIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validQ[g] <= 1'b0;
      else if (wrHere) validQ[g] <= strobe.setValid;
    end

    always_ff @(posedge clk) begin
      if (wrHere) begin
        pidQ[g]  <= ldPid;
        epnQ[g]  <= ldEpn;
        rpnQ[g]  <= ldRpn;
        sizeQ[g] <= ldSizeLog;
        attrQ[g] <= ldAttr;
        permQ[g] <= ldPerm;
      end
    end

    assign maskE[g]  = {ADDR_W{1'b1}} << sizeQ[g];
    assign matchE[g] = validQ[g]
                     && ((pidQ[g] == '0) || (pidQ[g] == curPid))
                     && ((lkAddr & maskE[g]) == epnQ[g]);
  end

  // lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchE[i]) selIdx = IDX_W'(i);
    end
  end

  assign anyHit   = |matchE;
  assign hitAttr  = anyHit ? attrQ[selIdx] : '0;
  assign hitPerm  = anyHit ? permQ[selIdx] : '0;
  assign realAddr = anyHit ? ((rpnQ[selIdx] & maskE[selIdx]) | (lkAddr & ~maskE[selIdx]))
                           : '0;

  // R12: a valid load is visible at the next edge
  a_r12_load_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.setValid) |=> validQ[$past(ldIdx)]);

  // R2: an invalid load leaves the slot out of lookup
  a_r2_invalid_load: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.setValid) |=> !matchE[$past(ldIdx)]);

  // R6: the chosen entry matches and no lower entry does
  a_r6_lowest_index: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> (matchE[selIdx] &&
                ((matchE & ((ENTRIES'(1) << selIdx) - ENTRIES'(1))) == '0)));

endmodule

// File: rtl/tlbz_control.sv
module tlbz_control
  import tlbz_pkg::*;
#(
  parameter int ATTR_W   = 8,
  parameter int PERM_W   = 3,
  parameter int ZSEL_W   = 4,
  parameter int ZSEL_LSB = 4,
  localparam int ZREG_W  = 2 * (2 ** ZSEL_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldEn,
  input  logic              ldValid,
  output strobe_t           strobe,
  input  logic              anyHit,
  input  logic [ATTR_W-1:0] hitAttr,
  input  logic [PERM_W-1:0] hitPerm,
  input  logic [ZREG_W-1:0] zoneReg,
  input  logic [1:0]        lkType,
  input  logic              lkUser,
  output logic [PERM_W-1:0] rights,
  output logic [1:0]        fault,
  output logic [31:0]       syndrome
);

  localparam logic [PERM_W-1:0] ALL_RIGHTS = '1;

  logic [ZSEL_W-1:0] zoneSel;
  logic [ZREG_W-1:0] zoneShift;
  logic [1:0]        zoneCode;
  logic              zoneFault;
  logic [PERM_W-1:0] needBit;
  fault_e            faultV;

  assign strobe.load     = ldEn;
  assign strobe.setValid = ldValid;

  assign zoneSel   = hitAttr[ZSEL_LSB +: ZSEL_W];
  // zone 0 sits at the top two bits
  assign zoneShift = zoneReg >> (ZREG_W - 2 - 2 * int'(zoneSel));
  assign zoneCode  = zoneShift[1:0];

  always_comb begin
    zoneFault = 1'b0;
    rights    = '0;
    if (anyHit) begin
      unique case (zoneCode)
        2'd3: rights = ALL_RIGHTS;
        2'd2: rights = lkUser ? hitPerm : ALL_RIGHTS;
        2'd1: rights = hitPerm;
        default: begin
          if (lkUser) zoneFault = 1'b1;
          else        rights    = hitPerm;
        end
      endcase
    end
  end

  always_comb begin
    unique case (access_e'(lkType))
      ACC_FETCH: needBit = PERM_W'(3'b100);
      ACC_STORE: needBit = PERM_W'(3'b010);
      default:   needBit = PERM_W'(3'b001);
    endcase
  end

  always_comb begin
    if (!anyHit)                     faultV = FLT_MISS;
    else if (zoneFault)              faultV = FLT_ZONE;
    else if ((rights & needBit) == 0) faultV = FLT_PROT;
    else                             faultV = FLT_NONE;
  end

  assign fault    = faultV;
  assign syndrome = (faultV == FLT_ZONE) ? ZONE_SYNDROME : 32'd0;

  // R11: a miss carries no rights
  a_r11_miss_no_rights: assert property (@(posedge clk) disable iff (!rstN)
    (fault == FLT_MISS) |-> (rights == '0 && syndrome == 32'd0));

  // R9: zone fault only on user accesses, with no rights
  a_r9_zone_user_only: assert property (@(posedge clk) disable iff (!rstN)
    (fault == FLT_ZONE) |-> (lkUser && rights == '0 && $countones(syndrome) == 1));

  // R10: protection faults carry a zero syndrome
  a_r10_prot_zero_syndrome: assert property (@(posedge clk) disable iff (!rstN)
    (fault == FLT_PROT) |-> (syndrome == 32'd0 && anyHit));

endmodule

// File: rtl/tlbz_top.sv
module tlbz_top
  import tlbz_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int PID_W   = 8,
  parameter int SIZE_W  = 5,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldEn,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic              ldValid,
  input  logic [PID_W-1:0]  ldPid,
  input  logic [ADDR_W-1:0] ldEpn,
  input  logic [ADDR_W-1:0] ldRpn,
  input  logic [SIZE_W-1:0] ldSizeLog,
  input  logic [7:0]        ldAttr,
  input  logic [2:0]        ldPerm,
  input  logic [31:0]       zoneReg,
  input  logic [PID_W-1:0]  curPid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [1:0]        lkType,
  input  logic              lkUser,
  output logic              hit,
  output logic [ADDR_W-1:0] realAddr,
  output logic [2:0]        rights,
  output logic [1:0]        fault,
  output logic [31:0]       syndrome
);

  strobe_t    strobe;
  logic [7:0] hitAttr;
  logic [2:0] hitPerm;

  tlbz_datapath #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .PID_W(PID_W),
    .SIZE_W(SIZE_W), .ATTR_W(8), .PERM_W(3)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ldIdx(ldIdx),
    .ldPid(ldPid), .ldEpn(ldEpn), .ldRpn(ldRpn), .ldSizeLog(ldSizeLog),
    .ldAttr(ldAttr), .ldPerm(ldPerm), .curPid(curPid), .lkAddr(lkAddr),
    .anyHit(hit), .hitAttr(hitAttr), .hitPerm(hitPerm), .realAddr(realAddr)
  );

  tlbz_control #(
    .ATTR_W(8), .PERM_W(3), .ZSEL_W(4), .ZSEL_LSB(4)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .ldValid(ldValid), .strobe(strobe),
    .anyHit(hit), .hitAttr(hitAttr), .hitPerm(hitPerm), .zoneReg(zoneReg),
    .lkType(lkType), .lkUser(lkUser), .rights(rights), .fault(fault),
    .syndrome(syndrome)
  );

endmodule

// File: tb/tlbz_top_tb.sv
module tlbz_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldEn = 1'b0;
  logic [2:0]  ldIdx = '0;
  logic        ldValid = 1'b0;
  logic [7:0]  ldPid = '0;
  logic [31:0] ldEpn = '0, ldRpn = '0;
  logic [4:0]  ldSizeLog = '0;
  logic [7:0]  ldAttr = '0;
  logic [2:0]  ldPerm = '0;
  logic [31:0] zoneReg = 32'h1B00_0000;
  logic [7:0]  curPid = '0;
  logic [31:0] lkAddr = '0;
  logic [1:0]  lkType = '0;
  logic        lkUser = 1'b0;
  logic        hit;
  logic [31:0] realAddr;
  logic [2:0]  rights;
  logic [1:0]  fault;
  logic [31:0] syndrome;

  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tlbz_top u_dut (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .ldIdx(ldIdx), .ldValid(ldValid),
    .ldPid(ldPid), .ldEpn(ldEpn), .ldRpn(ldRpn), .ldSizeLog(ldSizeLog),
    .ldAttr(ldAttr), .ldPerm(ldPerm), .zoneReg(zoneReg), .curPid(curPid),
    .lkAddr(lkAddr), .lkType(lkType), .lkUser(lkUser), .hit(hit),
    .realAddr(realAddr), .rights(rights), .fault(fault), .syndrome(syndrome)
  );

  typedef struct packed {
    logic [7:0]  pid;
    logic [31:0] addr;
    logic [1:0]  typ;   // 0 fetch, 1 load, 2 store
    logic        user;
    logic [31:0] zreg;
    logic        eHit;
    logic [31:0] eReal;
    logic [2:0]  eRights;
    logic [1:0]  eFault; // 0 none, 1 miss, 2 zone, 3 prot
    logic [31:0] eSyn;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    // R3 R5 R10: entry 0, zone 1, read allowed
    '{8'd5, 32'h0001_0123, 2'd1, 1'b1, 32'h1B00_0000, 1'b1, 32'h8000_0123, 3'b001, 2'd0, 32'd0, 8'd10},
    // R10: store on read-only page
    '{8'd5, 32'h0001_0123, 2'd2, 1'b1, 32'h1B00_0000, 1'b1, 32'h8000_0123, 3'b001, 2'd3, 32'd0, 8'd10},
    // R3 R6: tag mismatch on entry 0, entry 5 wins
    '{8'd6, 32'h0001_0123, 2'd1, 1'b1, 32'h1B00_0000, 1'b1, 32'hD000_0123, 3'b111, 2'd0, 32'd0, 8'd6},
    // R4 R8: 64 KB page, zone 2 privileged
    '{8'd6, 32'h0002_ABCD, 2'd2, 1'b0, 32'h1B00_0000, 1'b1, 32'h9000_ABCD, 3'b111, 2'd0, 32'd0, 8'd8},
    // R8: zone 2 user falls back to entry bits, fetch refused
    '{8'd6, 32'h0002_ABCD, 2'd0, 1'b1, 32'h1B00_0000, 1'b1, 32'h9000_ABCD, 3'b011, 2'd3, 32'd0, 8'd8},
    // R9: zone 0 user fault
    '{8'd7, 32'h0003_0456, 2'd1, 1'b1, 32'h1B00_0000, 1'b1, 32'hA000_0456, 3'b000, 2'd2, 32'h0040_0000, 8'd9},
    // R9: zone 0 privileged fetch uses entry bits
    '{8'd7, 32'h0003_0456, 2'd0, 1'b0, 32'h1B00_0000, 1'b1, 32'hA000_0456, 3'b101, 2'd0, 32'd0, 8'd9},
    // R9: zone 0 privileged store refused by entry bits
    '{8'd7, 32'h0003_0456, 2'd2, 1'b0, 32'h1B00_0000, 1'b1, 32'hA000_0456, 3'b101, 2'd3, 32'd0, 8'd9},
    // R8: zone 3 user store on zero-permission entry
    '{8'd1, 32'h0004_0FFF, 2'd2, 1'b1, 32'h1B00_0000, 1'b1, 32'hB000_0FFF, 3'b111, 2'd0, 32'd0, 8'd8},
    // R2 R11: invalid entry 4 only candidate
    '{8'd1, 32'h0005_0000, 2'd1, 1'b0, 32'h1B00_0000, 1'b0, 32'h0000_0000, 3'b000, 2'd1, 32'd0, 8'd11},
    // R4 R6: outside 4 KB page of entry 0, inside entry 5
    '{8'd5, 32'h0001_1000, 2'd1, 1'b1, 32'h1B00_0000, 1'b1, 32'hD000_1000, 3'b111, 2'd0, 32'd0, 8'd4},
    // R7: only zone 1 field changed to code 3
    '{8'd5, 32'h0001_0123, 2'd2, 1'b1, 32'h3B00_0000, 1'b1, 32'h8000_0123, 3'b111, 2'd0, 32'd0, 8'd7},
    // R11: unmapped fetch
    '{8'd9, 32'h0006_0000, 2'd0, 1'b0, 32'h1B00_0000, 1'b0, 32'h0000_0000, 3'b000, 2'd1, 32'd0, 8'd11}
  };

  task automatic check(input string tag, input logic eHit, input logic [31:0] eReal,
                       input logic [2:0] eRights, input logic [1:0] eFault,
                       input logic [31:0] eSyn);
    nRun++;
    if (hit !== eHit || realAddr !== eReal || rights !== eRights ||
        fault !== eFault || syndrome !== eSyn) begin
      nFail++;
      $display("FAIL %s: got hit=%0b real=%h rights=%b fault=%0d syn=%h, want hit=%0b real=%h rights=%b fault=%0d syn=%h",
               tag, hit, realAddr, rights, fault, syndrome, eHit, eReal, eRights, eFault, eSyn);
    end
  endtask

  task automatic lookup(input logic [7:0] p, input logic [31:0] a, input logic [1:0] t,
                        input logic u, input logic [31:0] z);
    curPid = p; lkAddr = a; lkType = t; lkUser = u; zoneReg = z;
    #1;
  endtask

  task automatic loadEntry(input logic [2:0] idx, input logic v, input logic [7:0] p,
                           input logic [31:0] epn, input logic [31:0] rpn,
                           input logic [4:0] sz, input logic [7:0] attr,
                           input logic [2:0] perm);
    @(negedge clk);
    ldEn = 1'b1; ldIdx = idx; ldValid = v; ldPid = p; ldEpn = epn; ldRpn = rpn;
    ldSizeLog = sz; ldAttr = attr; ldPerm = perm;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    lookup(8'd5, 32'h0001_0123, 2'd1, 1'b1, 32'h1B00_0000);
    check("R1 reset miss", 1'b0, 32'd0, 3'b000, 2'd1, 32'd0);

    // R12: entry 0 not visible in the request cycle, visible after the edge
    @(negedge clk);
    ldEn = 1'b1; ldIdx = 3'd0; ldValid = 1'b1; ldPid = 8'd5;
    ldEpn = 32'h0001_0000; ldRpn = 32'h8000_0000; ldSizeLog = 5'd12;
    ldAttr = 8'h10; ldPerm = 3'b001;
    #1;
    check("R12 before edge", 1'b0, 32'd0, 3'b000, 2'd1, 32'd0);
    @(negedge clk);
    ldEn = 1'b0;
    #1;
    check("R12 after edge", 1'b1, 32'h8000_0123, 3'b001, 2'd0, 32'd0);

    loadEntry(3'd1, 1'b1, 8'd0, 32'h0002_0000, 32'h9000_0000, 5'd16, 8'h20, 3'b011);
    loadEntry(3'd2, 1'b1, 8'd7, 32'h0003_0000, 32'hA000_0000, 5'd12, 8'h00, 3'b101);
    loadEntry(3'd3, 1'b1, 8'd0, 32'h0004_0000, 32'hB000_0000, 5'd12, 8'h30, 3'b000);
    loadEntry(3'd4, 1'b0, 8'd0, 32'h0005_0000, 32'hC000_0000, 5'd12, 8'h30, 3'b111);
    loadEntry(3'd5, 1'b1, 8'd0, 32'h0001_0000, 32'hD000_0000, 5'd16, 8'h30, 3'b000);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      lookup(VECS[i].pid, VECS[i].addr, VECS[i].typ, VECS[i].user, VECS[i].zreg);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].eHit, VECS[i].eReal,
            VECS[i].eRights, VECS[i].eFault, VECS[i].eSyn);
    end

    // R2: reloading entry 2 with valid low removes it
    loadEntry(3'd2, 1'b0, 8'd7, 32'h0003_0000, 32'hA000_0000, 5'd12, 8'h00, 3'b101);
    lookup(8'd7, 32'h0003_0456, 2'd0, 1'b0, 32'h1B00_0000);
    check("R2 invalidated", 1'b0, 32'd0, 3'b000, 2'd1, 32'd0);

    // R5: largest offset in the 64 KB page
    lookup(8'd3, 32'h0002_FFFF, 2'd1, 1'b1, 32'h1B00_0000);
    check("R5 top offset", 1'b1, 32'h9000_FFFF, 3'b011, 2'd0, 32'd0);

    // R1: reset again clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    lookup(8'd6, 32'h0002_ABCD, 2'd1, 1'b0, 32'h1B00_0000);
    check("R1 second reset", 1'b0, 32'd0, 3'b000, 2'd1, 32'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog: got running, want finished");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule